// File: doc/BRIEF.md
# Self-Timed Byte Program and Bulk Erase Sequencer

This block is the on-chip controller of a byte-wide non-volatile array. A host writes commands into a small command decoder. Programming a byte takes an arm code followed by a write that carries the address and data. Erasing the whole array takes an arm code followed by a confirm code. From there the sequencer works on its own. It strobes a program or erase pulse into the array model and times each pulse with an internal down-counter. After each pulse it reads the result back and compares it. It repeats pulses up to a parameterised attempt limit.

A bulk erase runs in three phases. First every byte is driven to 0x00 and each byte is checked. Then one erase pulse is applied to the whole array. Then every byte is checked for 0xFF, and the erase pulse is repeated while a byte still holds any cleared bit. The host needs no ready pin. While an operation runs, any read returns the inverse of bit 7 of the value the operation is aiming for. After the operation ends, reads return the stored bytes again. A sticky flag reports an operation that ran out of attempts. The array model can be built with one faulty bit so that both retry limits can be reached.

Top module: `flash_seq`

## Requirements
- R1: After reset, `busy` and `op_fail` are low, and every address reads 0xFF, except a cell configured as faulty.
- R2: A write of 0x5A followed by a write of (address, data) programs that byte. A program that verifies on the first pulse keeps `busy` high for exactly PGM_PULSE+1 cycles.
- R3: A program pulse only clears bits, so the stored byte becomes old AND data. If the byte does not equal the data after PGM_TRIES pulses, `op_fail` is set and the block goes idle. `busy` then lasts PGM_TRIES*(PGM_PULSE+1) cycles.
- R4: A write of 0xC3 followed by a write of 0x3C erases the whole array. With no faults, every byte then reads 0xFF and `busy` lasts N*(PGM_PULSE+1)+ERS_PULSE+N cycles, where N = 2^ADDR_W.
- R5: After 0xC3, any write other than 0x3C drops the armed state and starts nothing. A lone 0x3C starts nothing.
- R6: While `busy` is high, `rd_data` is {~bit7 of the target, 7'b0}. The target is the program data, or 0xFF for an erase. The value holds steady for the whole operation.
- R7: If some byte still fails the 0xFF check after ERS_TRIES erase pulses, `op_fail` is set. With a fault at address F, `busy` lasts N*(PGM_PULSE+1)+ERS_TRIES*(ERS_PULSE+F+1) cycles.
- R8: `op_fail` stays set while idle and clears at the edge where the next operation is accepted.
- R9: Writes made while `busy` is high are ignored and leave no armed state. No strobe is active while idle.
- R10: If the pre-programming of a byte fails PGM_TRIES times, the erase stops with `op_fail` set. The array is not erased, and lower addresses stay at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host command write strobe |
| wr_addr | input | ADDR_W | Address carried by a program data write |
| wr_data | input | 8 | Command code or program data |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 8 | Array byte, or the polling status while busy |
| busy | output | 1 | An operation is in progress |
| op_fail | output | 1 | Sticky attempt-limit failure of the last operation |

## Verification
The hardest conditions to reach from the ports are the two attempt limits, because a healthy array always verifies on the first pulse. To reach them, the bench builds two extra instances whose array model has one stuck bit. A stuck-high bit makes the pre-program check fail. A stuck-low bit makes the erase check fail. Busy durations are then measured and compared with closed-form cycle counts, which expose the exact number of pulses issued. A command burst issued in the middle of a program shows that writes made while busy are dropped.

// File: rtl/flash_seq_pkg.sv
// Shared types and constants for the program/erase sequencer.
// Assumes an 8-bit data path; the command codes are fixed by the host protocol.
package flash_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PGM_PULSE,
        ST_PGM_CHECK,
        ST_PRE_PULSE,
        ST_PRE_CHECK,
        ST_ERS_PULSE,
        ST_ERS_CHECK
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PGM,
        OP_ERS
    } op_kind_t;

    localparam logic [7:0] CODE_PGM_ARM = 8'h5A;
    localparam logic [7:0] CODE_ERS_ARM = 8'hC3;
    localparam logic [7:0] CODE_ERS_GO  = 8'h3C;
    localparam logic [7:0] BYTE_ERASED  = 8'hFF;
    localparam logic [7:0] BYTE_CLEAR   = 8'h00;
endpackage

// File: rtl/flash_cmd_decode.sv
// Command decoder: it tracks the two-write command protocol and raises a
// one-cycle operation request. Assumes the caller gates nothing itself;
// writes made while busy are dropped here and do not change the armed state.
module flash_cmd_decode
    import flash_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       busy,
    output op_kind_t   op_req
);
    op_kind_t armed;
    logic     take;

    assign take = wr_en && !busy;

    // Turn the second write of a sequence into a request.
    always_comb begin
        op_req = OP_NONE;
        if (take) begin
            if (armed == OP_PGM)
                op_req = OP_PGM;
            else if (armed == OP_ERS && wr_data == CODE_ERS_GO)
                op_req = OP_ERS;
        end
    end

    // Arm on a setup code; any following accepted write disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= OP_NONE;
        end else if (take) begin
            if (armed != OP_NONE)
                armed <= OP_NONE;
            else if (wr_data == CODE_PGM_ARM)
                armed <= OP_PGM;
            else if (wr_data == CODE_ERS_ARM)
                armed <= OP_ERS;
            else
                armed <= OP_NONE;
        end
    end
endmodule

// File: rtl/flash_pulse_timer.sv
// Pulse width timer: a down-counter loaded with width-1; expired is high
// in the last cycle of a pulse. Assumes load and countdown never coincide
// with a need to hold the value.
module flash_pulse_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    assign expired = (cnt == '0);

    // Load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/flash_cell_array.sv
// Behavioural byte array standing in for the cell matrix. A program strobe
// ANDs data into one byte (bits can only clear); an erase strobe sets every
// byte to 0xFF. An optional single-bit fault (mode 1 stuck high, mode 2
// stuck low) is applied on every update. Reset loads the erased state.
module flash_cell_array #(
    parameter int ADDR_W     = 8,
    parameter int STUCK_MODE = 0,
    parameter int STUCK_ADDR = 0,
    parameter int STUCK_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [7:0]        pgm_data,
    input  logic              ers_en,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [7:0]        host_q,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [7:0]        chk_q
);
    localparam int         DEPTH      = 1 << ADDR_W;
    localparam logic [7:0] FAULT_MASK = 8'(1) << STUCK_BIT;

    logic [7:0] mem [DEPTH];

    function automatic logic [7:0] apply_fault(input logic [ADDR_W-1:0] a,
                                               input logic [7:0] v);
        if (STUCK_MODE == 1 && a == ADDR_W'(STUCK_ADDR))
            return v | FAULT_MASK;
        else if (STUCK_MODE == 2 && a == ADDR_W'(STUCK_ADDR))
            return v & ~FAULT_MASK;
        else
            return v;
    endfunction

    assign host_q = mem[host_addr];
    assign chk_q  = mem[chk_addr];

    // Apply reset, erase or program pulses to the stored bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || ers_en) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= apply_fault(ADDR_W'(i), 8'hFF);
        end else if (pgm_en) begin
            mem[pgm_addr] <= apply_fault(pgm_addr, mem[pgm_addr] & pgm_data);
        end
    end
endmodule

// File: rtl/flash_seq.sv
// Top of the self-timed sequencer. It accepts requests from the command
// decoder, runs program/verify loops and the pre-program, erase and verify
// phases of a bulk erase, and returns polling status on reads while busy.
// Assumes the array settles within the clock cycle after a strobe ends.
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PGM_PULSE  = 8,
    parameter int ERS_PULSE  = 64,
    parameter int PGM_TRIES  = 25,
    parameter int ERS_TRIES  = 1000,
    parameter int STUCK_MODE = 0,
    parameter int STUCK_ADDR = 0,
    parameter int STUCK_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              op_fail
);
    localparam int TMR_W = $clog2(((PGM_PULSE > ERS_PULSE) ? PGM_PULSE : ERS_PULSE) + 1);
    localparam int PT_W  = $clog2(PGM_TRIES + 1);
    localparam int ET_W  = $clog2(ERS_TRIES + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    seq_state_t        state, nxt;
    op_kind_t          op_req;
    logic [ADDR_W-1:0] tgt_addr;
    logic [7:0]        tgt_data;
    logic              exp7;
    logic [PT_W-1:0]   ptries;
    logic [ET_W-1:0]   etries;
    logic              fail_q;
    logic              tmr_load, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic              pgm_on, ers_on;
    logic [7:0]        pgm_byte, host_q, chk_q;
    logic              chk_ok, at_last, ptry_last, etry_last, give_up, accept;

    flash_cmd_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .busy    (busy),
        .op_req  (op_req)
    );

    flash_pulse_timer #(.CNT_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    flash_cell_array #(
        .ADDR_W     (ADDR_W),
        .STUCK_MODE (STUCK_MODE),
        .STUCK_ADDR (STUCK_ADDR),
        .STUCK_BIT  (STUCK_BIT)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pgm_en    (pgm_on),
        .pgm_addr  (tgt_addr),
        .pgm_data  (pgm_byte),
        .ers_en    (ers_on),
        .host_addr (rd_addr),
        .host_q    (host_q),
        .chk_addr  (tgt_addr),
        .chk_q     (chk_q)
    );

    assign busy     = (state != ST_IDLE);
    assign op_fail  = fail_q;
    assign accept   = (state == ST_IDLE) && (op_req != OP_NONE);
    assign pgm_on   = (state == ST_PGM_PULSE) || (state == ST_PRE_PULSE);
    assign ers_on   = (state == ST_ERS_PULSE);
    assign pgm_byte = (state == ST_PRE_PULSE) ? BYTE_CLEAR : tgt_data;
    assign rd_data  = busy ? {~exp7, 7'b0} : host_q;

    assign at_last   = (tgt_addr == LAST_ADDR);
    assign ptry_last = (ptries == PT_W'(PGM_TRIES - 1));
    assign etry_last = (etries == ET_W'(ERS_TRIES - 1));

    // Compare the byte under check with what the current phase expects.
    always_comb begin
        case (state)
            ST_PGM_CHECK: chk_ok = (chk_q == tgt_data);
            ST_PRE_CHECK: chk_ok = (chk_q == BYTE_CLEAR);
            ST_ERS_CHECK: chk_ok = (chk_q == BYTE_ERASED);
            default:      chk_ok = 1'b0;
        endcase
    end

    // Next-state selection for the program and erase sequences.
    always_comb begin
        nxt     = state;
        give_up = 1'b0;
        case (state)
            ST_IDLE: begin
                if (op_req == OP_PGM)      nxt = ST_PGM_PULSE;
                else if (op_req == OP_ERS) nxt = ST_PRE_PULSE;
            end
            ST_PGM_PULSE: if (tmr_done) nxt = ST_PGM_CHECK;
            ST_PGM_CHECK: begin
                if (chk_ok)         nxt = ST_IDLE;
                else if (ptry_last) begin nxt = ST_IDLE; give_up = 1'b1; end
                else                nxt = ST_PGM_PULSE;
            end
            ST_PRE_PULSE: if (tmr_done) nxt = ST_PRE_CHECK;
            ST_PRE_CHECK: begin
                if (chk_ok)         nxt = at_last ? ST_ERS_PULSE : ST_PRE_PULSE;
                else if (ptry_last) begin nxt = ST_IDLE; give_up = 1'b1; end
                else                nxt = ST_PRE_PULSE;
            end
            ST_ERS_PULSE: if (tmr_done) nxt = ST_ERS_CHECK;
            ST_ERS_CHECK: begin
                if (chk_ok)         nxt = at_last ? ST_IDLE : ST_ERS_CHECK;
                else if (etry_last) begin nxt = ST_IDLE; give_up = 1'b1; end
                else                nxt = ST_ERS_PULSE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Start the pulse timer whenever a pulse phase is entered.
    always_comb begin
        tmr_load = (nxt != state) &&
                   (nxt == ST_PGM_PULSE || nxt == ST_PRE_PULSE || nxt == ST_ERS_PULSE);
        tmr_val  = (nxt == ST_ERS_PULSE) ? TMR_W'(ERS_PULSE - 1) : TMR_W'(PGM_PULSE - 1);
    end

    // Sequencer registers: state, target, attempt counters and fail flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tgt_addr <= '0;
            tgt_data <= '0;
            exp7     <= 1'b0;
            ptries   <= '0;
            etries   <= '0;
            fail_q   <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                fail_q <= 1'b0;
                ptries <= '0;
                etries <= '0;
                if (op_req == OP_PGM) begin
                    tgt_addr <= wr_addr;
                    tgt_data <= wr_data;
                    exp7     <= wr_data[7];
                end else begin
                    tgt_addr <= '0;
                    exp7     <= 1'b1;
                end
            end else begin
                if (give_up)
                    fail_q <= 1'b1;
                case (state)
                    ST_PGM_CHECK: if (!chk_ok) ptries <= ptries + 1'b1;
                    ST_PRE_CHECK: begin
                        if (chk_ok) begin
                            ptries   <= '0;
                            tgt_addr <= at_last ? '0 : tgt_addr + 1'b1;
                        end else begin
                            ptries <= ptries + 1'b1;
                        end
                    end
                    ST_ERS_CHECK: begin
                        if (chk_ok) begin
                            if (!at_last) tgt_addr <= tgt_addr + 1'b1;
                        end else begin
                            etries   <= etries + 1'b1;
                            tgt_addr <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_seq_chk.sv
// Property checker for the sequencer, attached to every instance by bind.
// Assumes the strobes and the erase attempt counter are visible in the top.
module flash_seq_chk #(
    parameter int ERS_TRIES = 1000,
    parameter int ET_W      = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            op_fail,
    input logic [7:0]      rd_data,
    input logic            pgm_on,
    input logic            ers_on,
    input logic [ET_W-1:0] etries
);
    assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_on, ers_on}));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pgm_on && !ers_on));

    assert_poll_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_data));

    assert_fail_ends_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_fail) |-> !busy);

    assert_erase_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        etries <= ET_W'(ERS_TRIES));
endmodule

bind flash_seq flash_seq_chk #(
    .ERS_TRIES (ERS_TRIES),
    .ET_W      (ET_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .op_fail (op_fail),
    .rd_data (rd_data),
    .pgm_on  (pgm_on),
    .ers_on  (ers_on),
    .etries  (etries)
);

// File: tb/flash_seq_test.sv
`timescale 1ns/1ps
module flash_seq_test;
    localparam int AW = 4;
    localparam int N  = 1 << AW;
    localparam int PW = 4;
    localparam int EW = 8;
    localparam int MP = 3;
    localparam int ME = 2;
    localparam int HI_ADDR = 5;
    localparam int LO_ADDR = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic          we [3];
    logic [AW-1:0] wa [3];
    logic [AW-1:0] ra [3];
    logic [7:0]    wd [3];
    logic [7:0]    rq [3];
    logic          bz [3];
    logic          fl [3];
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    flash_seq #(.ADDR_W(AW), .PGM_PULSE(PW), .ERS_PULSE(EW), .PGM_TRIES(MP),
                .ERS_TRIES(ME)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(we[0]), .wr_addr(wa[0]), .wr_data(wd[0]),
        .rd_addr(ra[0]), .rd_data(rq[0]), .busy(bz[0]), .op_fail(fl[0]));

    flash_seq #(.ADDR_W(AW), .PGM_PULSE(PW), .ERS_PULSE(EW), .PGM_TRIES(MP),
                .ERS_TRIES(ME), .STUCK_MODE(1), .STUCK_ADDR(HI_ADDR), .STUCK_BIT(0)) uut_hi (
        .clk(clk), .rst_n(rst_n), .wr_en(we[1]), .wr_addr(wa[1]), .wr_data(wd[1]),
        .rd_addr(ra[1]), .rd_data(rq[1]), .busy(bz[1]), .op_fail(fl[1]));

    flash_seq #(.ADDR_W(AW), .PGM_PULSE(PW), .ERS_PULSE(EW), .PGM_TRIES(MP),
                .ERS_TRIES(ME), .STUCK_MODE(2), .STUCK_ADDR(LO_ADDR), .STUCK_BIT(3)) uut_lo (
        .clk(clk), .rst_n(rst_n), .wr_en(we[2]), .wr_addr(wa[2]), .wr_data(wd[2]),
        .rd_addr(ra[2]), .rd_data(rq[2]), .busy(bz[2]), .op_fail(fl[2]));

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int u, input int a, input int d);
        @(negedge clk);
        we[u] = 1'b1;
        wa[u] = AW'(a);
        wd[u] = 8'(d);
        @(negedge clk);
        we[u] = 1'b0;
    endtask

    task automatic rd(input int u, input int a, output int q);
        ra[u] = AW'(a);
        #1;
        q = int'(rq[u]);
    endtask

    task automatic wait_idle(input int u, output int cyc);
        cyc = 0;
        while (bz[u] && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int q, cyc, pat;
        for (int u = 0; u < 3; u++) begin
            we[u] = 1'b0; wa[u] = '0; wd[u] = '0; ra[u] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 busy", int'(bz[0]), 0);
        check("R1 fail", int'(fl[0]), 0);
        for (int a = 0; a < N; a++) begin
            rd(0, a, q); check("R1 erased", q, 'hFF);
        end
        rd(2, LO_ADDR, q); check("R1 fault cell", q, 'hF7);

        // R2 / R6: program every address with a computed pattern
        for (int a = 0; a < N; a++) begin
            pat = (a * 37 + 11) & 'hFF;
            wr(0, 0, 'h5A);
            wr(0, a, pat);
            rd(0, a, q); check("R6 program poll", q, ((pat >> 7) & 1) ? 'h00 : 'h80);
            wait_idle(0, cyc); check("R2 program cycles", cyc, PW + 1);
            check("R2 no fail", int'(fl[0]), 0);
        end
        for (int a = 0; a < N; a++) begin
            rd(0, a, q); check("R2 readback", q, (a * 37 + 11) & 'hFF);
        end

        // R4 / R6: bulk erase
        wr(0, 0, 'hC3);
        wr(0, 0, 'h3C);
        rd(0, 0, q); check("R6 erase poll", q, 'h00);
        wait_idle(0, cyc); check("R4 erase cycles", cyc, N * (PW + 1) + EW + N);
        check("R4 no fail", int'(fl[0]), 0);
        for (int a = 0; a < N; a++) begin
            rd(0, a, q); check("R4 erased", q, 'hFF);
        end

        // R3: pulses only clear bits; setting bits exhausts the attempts
        wr(0, 0, 'h5A); wr(0, 2, 'h0F);
        wait_idle(0, cyc); check("R3 first program", cyc, PW + 1);
        wr(0, 0, 'h5A); wr(0, 2, 'hF0);
        wait_idle(0, cyc); check("R3 retry cycles", cyc, MP * (PW + 1));
        check("R3 fail flag", int'(fl[0]), 1);
        rd(0, 2, q); check("R3 AND result", q, 'h00);

        // R8: sticky until next accepted operation
        repeat (3) @(negedge clk);
        check("R8 fail held", int'(fl[0]), 1);
        wr(0, 0, 'h5A); wr(0, 4, 'h55);
        check("R8 fail cleared", int'(fl[0]), 0);
        wait_idle(0, cyc); check("R8 program cycles", cyc, PW + 1);

        // R9: writes during busy are ignored
        wr(0, 0, 'h5A); wr(0, 6, 'hA5);
        check("R9 busy", int'(bz[0]), 1);
        wr(0, 0, 'hC3);
        wr(0, 0, 'h3C);
        repeat (4) @(negedge clk);
        check("R9 idle after", int'(bz[0]), 0);
        rd(0, 6, q); check("R9 byte kept", q, 'hA5);
        rd(0, 4, q); check("R9 no erase", q, 'h55);
        wr(0, 0, 'h3C);
        check("R9 no armed state", int'(bz[0]), 0);

        // R5: aborted and lone confirm
        wr(0, 0, 'hC3); wr(0, 0, 'h77);
        check("R5 abort", int'(bz[0]), 0);
        wr(0, 0, 'h3C);
        check("R5 lone confirm", int'(bz[0]), 0);
        rd(0, 6, q); check("R5 array kept", q, 'hA5);

        // R10: pre-program failure stops the erase
        wr(1, 0, 'hC3); wr(1, 0, 'h3C);
        wait_idle(1, cyc); check("R10 cycles", cyc, (HI_ADDR + MP) * (PW + 1));
        check("R10 fail", int'(fl[1]), 1);
        for (int a = 0; a < HI_ADDR; a++) begin
            rd(1, a, q); check("R10 preprogrammed", q, 'h00);
        end
        rd(1, HI_ADDR, q); check("R10 stuck byte", q, 'h01);
        rd(1, HI_ADDR + 1, q); check("R10 untouched", q, 'hFF);

        // R7: erase verify failure exhausts the erase attempts
        wr(2, 0, 'hC3); wr(2, 0, 'h3C);
        wait_idle(2, cyc); check("R7 cycles", cyc, N * (PW + 1) + ME * (EW + LO_ADDR + 1));
        check("R7 fail", int'(fl[2]), 1);
        rd(2, LO_ADDR, q); check("R7 bad byte", q, 'hF7);
        rd(2, 0, q); check("R7 erased", q, 'hFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule